// File: doc/BRIEF.md
# Step Sequencer Transport Controller

This block runs the transport of a step sequencer. Three inputs arrive from outside the chip with no timing relation to the system clock: a clock trigger, a reset trigger, and a transport input. A second transport input carries stop pulses. Each input passes through a synchronizer chain and an edge detector. The block keeps a step index that counts up on each accepted clock trigger and wraps at a length set at run time. It also keeps a running flag and issues a one-cycle advance strobe whenever the index is stepped.

A reset trigger sets the index to zero at once and arms a pending flag. The next accepted clock trigger, or one that arrives in the same cycle as the reset, lands the sequence on the first step instead of moving past it. This way a clock that races a reset never skips the first step and never plays it twice. For a configurable number of cycles after a reset edge, clock triggers are dropped. The transport runs in one of two modes. In level mode the input is a run gate. In pulse mode a start pulse sets the running flag and a stop pulse clears it.

Top module: `seq_transport`

## Requirements
- R1: While `rst_i` is high, the next clock edge sets `step_o` to 0, `running_o` to 0 and `advance_o` to 0, and clears the pending flag and the lockout. After release, the first accepted clock trigger moves the index from 0 to 1.
- R2: An accepted clock trigger raises `advance_o` for exactly one cycle and moves `step_o` up by one. The latency is three clock edges after the input changes between edges: two synchronizer stages, then one evaluation register.
- R3: The index counts from 0 to `len_i`-1 and goes back to 0 on the next accepted trigger. With `len_i` = 1 the index stays at 0, but each accepted trigger still pulses `advance_o`. A `len_i` of 0 is treated as 1.
- R4: With `pulse_mode_i` = 0, a rising edge on `run_i` sets `running_o` and a falling edge clears it. Clock triggers that arrive while `running_o` is low cause no strobe and no index change.
- R5: With `pulse_mode_i` = 1, a rising edge on `run_i` sets `running_o` and a rising edge on `stop_i` clears it. `running_o` holds its value after the pulses end. When a start edge and a stop edge come in the same cycle, stop wins.
- R6: A rising edge on `trig_rst_i` sets `step_o` to 0 without an `advance_o` pulse and arms the pending flag.
- R7: While the pending flag is armed, the next accepted clock trigger gives `step_o` = 0 together with an `advance_o` pulse and clears the flag. The trigger after that gives step 1.
- R8: When a clock edge and a reset edge are evaluated in the same cycle while running, the result is `step_o` = 0 with one `advance_o` pulse, and the flag ends up cleared. The next accepted trigger gives step 1.
- R9: For `LOCKOUT_CYCLES` cycles after a reset edge is evaluated, clock triggers are dropped: no strobe, no index change, and the pending flag stays armed.
- R10: A clock trigger that is ignored because the transport is paused does not clear an armed pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous system reset, active high |
| trig_clk_i | input | 1 | Asynchronous clock trigger |
| trig_rst_i | input | 1 | Asynchronous reset trigger |
| run_i | input | 1 | Run gate in level mode, start pulse in pulse mode |
| stop_i | input | 1 | Stop pulse, used in pulse mode only |
| pulse_mode_i | input | 1 | 0 = level transport, 1 = start/stop pulses |
| len_i | input | LEN_W | Sequence length, 1 to MAX_LEN |
| step_o | output | IDX_W | Current step index |
| running_o | output | 1 | Transport running flag |
| advance_o | output | 1 | One-cycle strobe per accepted clock trigger |

## Verification
Every result is due on the third rising clock edge after an input changes between edges. That covers `step_o`, `advance_o` and `running_o` alike. The latency check drives the clock trigger on a falling edge and samples `advance_o` after each of the next four rising edges. It expects the strobe only after the third. The other scenarios hold each trigger for three cycles and then idle for four, so every result has settled before it is read on a falling edge. A monitor counts strobes on falling edges, and dropped triggers are checked as a count that has not changed. Lockout scenarios wait more than `LOCKOUT_CYCLES` cycles before sending the clock trigger that must be accepted.

// File: rtl/seq_transport_pkg.sv
package seq_transport_pkg;

   typedef enum logic {
      XPORT_LEVEL = 1'b0,
      XPORT_PULSE = 1'b1
   } xport_mode_e;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   function automatic int unsigned idx_bits(input int unsigned depth);
      return (depth < 3) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/seq_sync_edge.sv
module seq_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("seq_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] & prev_q;

   p_rise_spaced_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> !rise_o);

endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
   import seq_transport_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic pulse_mode_i,
   input  logic go_rise_i,
   input  logic go_fall_i,
   input  logic halt_rise_i,
   output logic running_o
);

   xport_mode_e mode;
   logic        run_q;

   assign mode = xport_mode_e'(pulse_mode_i);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         run_q <= 1'b0;
      end else begin
         case (mode)
            XPORT_PULSE: begin
               if (halt_rise_i)    run_q <= 1'b0;
               else if (go_rise_i) run_q <= 1'b1;
            end
            default: begin
               if (go_rise_i)      run_q <= 1'b1;
               else if (go_fall_i) run_q <= 1'b0;
            end
         endcase
      end
   end

   assign running_o = run_q;

   p_stop_wins_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (pulse_mode_i && halt_rise_i) |=> !running_o);

   p_gate_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!pulse_mode_i && go_fall_i) |=> !running_o);

   p_start_sets_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (go_rise_i && !halt_rise_i) |=> running_o);

endmodule

// File: rtl/seq_step_core.sv
module seq_step_core
   import seq_transport_pkg::*;
#(
   parameter int MAX_LEN        = 16,
   parameter int LOCKOUT_CYCLES = 48000,
   localparam int LEN_W = cnt_bits(MAX_LEN),
   localparam int IDX_W = idx_bits(MAX_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             run_i,
   input  logic             clk_rise_i,
   input  logic             rst_rise_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [IDX_W-1:0] step_o,
   output logic             adv_o
);

   localparam int LK_W = cnt_bits(LOCKOUT_CYCLES);

   if (MAX_LEN < 1 || MAX_LEN > 256) begin : g_bad_len
      $error("seq_step_core: MAX_LEN must lie in 1..256");
   end
   if (LOCKOUT_CYCLES < 0) begin : g_bad_lock
      $error("seq_step_core: LOCKOUT_CYCLES must not be negative");
   end

   logic [IDX_W-1:0] step_q;
   logic             adv_q;
   logic             pend_q;
   logic             lock_busy;
   logic [LEN_W-1:0] eff_len;
   logic [LEN_W-1:0] last_idx;
   logic             at_last;
   logic             clk_ok;
   logic             land;

   // Clamp the run-time length to 1..MAX_LEN
   always_comb begin
      if (len_i == '0)                     eff_len = LEN_W'(1);
      else if (len_i > LEN_W'(MAX_LEN))    eff_len = LEN_W'(MAX_LEN);
      else                                 eff_len = len_i;
   end

   assign last_idx = eff_len - LEN_W'(1);
   assign at_last  = (LEN_W'(step_q) >= last_idx);

   // A reset edge in the same evaluation cycle overrides an active lockout
   assign clk_ok = clk_rise_i & run_i & (~lock_busy | rst_rise_i);
   assign land   = pend_q | rst_rise_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         step_q <= '0;
         adv_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         adv_q <= clk_ok;
         if (clk_ok) begin
            pend_q <= 1'b0;
            if (land || at_last) step_q <= '0;
            else                 step_q <= step_q + IDX_W'(1);
         end else if (rst_rise_i) begin
            step_q <= '0;
            pend_q <= 1'b1;
         end
      end
   end

   if (LOCKOUT_CYCLES == 0) begin : g_no_lock
      assign lock_busy = 1'b0;
   end else begin : g_lock
      logic [LK_W-1:0] cnt_q;
      always_ff @(posedge clk_i) begin
         if (rst_i)               cnt_q <= '0;
         else if (rst_rise_i)     cnt_q <= LK_W'(LOCKOUT_CYCLES);
         else if (cnt_q != '0)    cnt_q <= cnt_q - LK_W'(1);
      end
      assign lock_busy = (cnt_q != '0);
   end

   assign step_o = step_q;
   assign adv_o  = adv_q;

   p_adv_one_cycle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      adv_o |=> !adv_o);

   p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (clk_ok && !land && at_last) |=> (step_o == '0));

   p_paused_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      !run_i |=> !adv_o);

   p_reset_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (rst_rise_i && !clk_ok) |=> (step_o == '0 && !adv_o && pend_q));

   p_land_first_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (clk_ok && pend_q) |=> (step_o == '0 && adv_o && !pend_q));

   p_same_cycle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (clk_rise_i && rst_rise_i && run_i) |=> (step_o == '0 && adv_o && !pend_q));

   p_lockout_drop_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (lock_busy && !rst_rise_i) |=> !adv_o);

   p_pend_kept_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (pend_q && !clk_ok) |=> pend_q);

endmodule

// File: rtl/seq_transport.sv
module seq_transport
   import seq_transport_pkg::*;
#(
   parameter int MAX_LEN        = 16,
   parameter int LOCKOUT_CYCLES = 48000,
   parameter int SYNC_STAGES    = 2,
   localparam int LEN_W = cnt_bits(MAX_LEN),
   localparam int IDX_W = idx_bits(MAX_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             trig_clk_i,
   input  logic             trig_rst_i,
   input  logic             run_i,
   input  logic             stop_i,
   input  logic             pulse_mode_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [IDX_W-1:0] step_o,
   output logic             running_o,
   output logic             advance_o
);

   localparam int N_IN = 4;
   localparam int I_CLK  = 0;
   localparam int I_RST  = 1;
   localparam int I_RUN  = 2;
   localparam int I_STOP = 3;

   logic [N_IN-1:0] raw_in;
   logic [N_IN-1:0] lvl;
   logic [N_IN-1:0] rise;
   logic [N_IN-1:0] fall;
   logic            running;

   assign raw_in = {stop_i, run_i, trig_rst_i, trig_clk_i};

   for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
      seq_sync_edge #(
         .STAGES (SYNC_STAGES)
      ) u_sync (
         .clk_i   (clk_i),
         .rst_i   (rst_i),
         .async_i (raw_in[gi]),
         .level_o (lvl[gi]),
         .rise_o  (rise[gi]),
         .fall_o  (fall[gi])
      );
   end

   logic unused_edges;
   assign unused_edges = &{1'b0, lvl, fall[I_CLK], fall[I_RST], fall[I_STOP]};

   seq_run_ctrl u_run (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .pulse_mode_i (pulse_mode_i),
      .go_rise_i    (rise[I_RUN]),
      .go_fall_i    (fall[I_RUN]),
      .halt_rise_i  (rise[I_STOP]),
      .running_o    (running)
   );

   seq_step_core #(
      .MAX_LEN        (MAX_LEN),
      .LOCKOUT_CYCLES (LOCKOUT_CYCLES)
   ) u_core (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .run_i      (running),
      .clk_rise_i (rise[I_CLK]),
      .rst_rise_i (rise[I_RST]),
      .len_i      (len_i),
      .step_o     (step_o),
      .adv_o      (advance_o)
   );

   assign running_o = running;

   p_reset_state_r1: assert property (@(posedge clk_i)
      $past(rst_i) |-> (step_o == '0 && !running_o && !advance_o));

endmodule

// File: tb/seq_transport_tb_top.sv
module seq_transport_tb_top;

   localparam int CLK_P  = 10;
   localparam int LOCK   = 30;
   localparam int MAXL   = 16;

   logic       clk;
   logic       rst;
   logic       trig_clk;
   logic       trig_rst;
   logic       run;
   logic       stop;
   logic       pmode;
   logic [4:0] len;
   logic [3:0] step;
   logic       running;
   logic       advance;

   int n_chk  = 0;
   int n_fail = 0;
   int adv_cnt = 0;

   seq_transport #(
      .MAX_LEN        (MAXL),
      .LOCKOUT_CYCLES (LOCK),
      .SYNC_STAGES    (2)
   ) dut_i (
      .clk_i        (clk),
      .rst_i        (rst),
      .trig_clk_i   (trig_clk),
      .trig_rst_i   (trig_rst),
      .run_i        (run),
      .stop_i       (stop),
      .pulse_mode_i (pmode),
      .len_i        (len),
      .step_o       (step),
      .running_o    (running),
      .advance_o    (advance)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   always @(negedge clk) if (!rst && advance) adv_cnt++;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk) trig_clk = 1'b1;
      idle(3);
      trig_clk = 1'b0;
      idle(4);
   endtask

   task automatic rst_trig();
      @(negedge clk) trig_rst = 1'b1;
      idle(3);
      trig_rst = 1'b0;
      idle(4);
   endtask

   task automatic both_trig();
      @(negedge clk) begin trig_clk = 1'b1; trig_rst = 1'b1; end
      idle(3);
      trig_clk = 1'b0; trig_rst = 1'b0;
      idle(4);
   endtask

   task automatic set_run(input logic v);
      @(negedge clk) run = v;
      idle(4);
   endtask

   task automatic t_reset_state();
      chk("R1 step after reset", step, 0);
      chk("R1 running after reset", running, 0);
      chk("R1 advance after reset", advance, 0);
   endtask

   task automatic t_latency();
      set_run(1'b1);
      chk("R4 gate high sets running", running, 1);
      @(negedge clk) trig_clk = 1'b1;
      @(negedge clk) chk("R2 no strobe after 1 edge", advance, 0);
      @(negedge clk) chk("R2 no strobe after 2 edges", advance, 0);
      @(negedge clk) begin
         chk("R2 strobe after 3 edges", advance, 1);
         chk("R1 first step after reset is 1", step, 1);
      end
      @(negedge clk) chk("R2 strobe lasts one cycle", advance, 0);
      trig_clk = 1'b0;
      idle(4);
   endtask

   task automatic t_wrap();
      int c0;
      len = 5'd4;
      c0 = adv_cnt;
      tick(); chk("R2 step 2", step, 2);
      tick(); chk("R3 step 3 at last", step, 3);
      tick(); chk("R3 wrap to 0", step, 0);
      chk("R2 one strobe per trigger", adv_cnt - c0, 3);
      len = 5'd1;
      c0 = adv_cnt;
      tick(); tick();
      chk("R3 length 1 stays at 0", step, 0);
      chk("R3 length 1 still strobes", adv_cnt - c0, 2);
      len = 5'd0;
      tick();
      chk("R3 length 0 acts as 1", step, 0);
      len = 5'd8;
      tick(); tick();
      chk("R2 count to 2", step, 2);
   endtask

   task automatic t_pause_and_pending();
      int c0;
      set_run(1'b0);
      chk("R4 gate low clears running", running, 0);
      c0 = adv_cnt;
      tick();
      chk("R4 paused trigger no strobe", adv_cnt - c0, 0);
      chk("R4 paused trigger keeps step", step, 2);
      rst_trig();
      chk("R6 reset edge zeroes step", step, 0);
      chk("R6 reset edge gives no strobe", adv_cnt - c0, 0);
      idle(LOCK + 5);
      tick();
      set_run(1'b1);
      tick();
      chk("R10 pending kept over paused trigger, land on 0", step, 0);
      chk("R7 landing trigger strobes", adv_cnt - c0, 1);
      tick();
      chk("R7 trigger after landing gives 1", step, 1);
   endtask

   task automatic t_lockout();
      int c0;
      tick();
      chk("R2 step 2 before lockout test", step, 2);
      rst_trig();
      chk("R6 reset edge zeroes step while running", step, 0);
      c0 = adv_cnt;
      tick();
      chk("R9 trigger in lockout dropped", adv_cnt - c0, 0);
      chk("R9 step unchanged in lockout", step, 0);
      idle(LOCK + 5);
      tick();
      chk("R9 pending survives lockout, land on 0", step, 0);
      chk("R9 landing strobe after lockout", adv_cnt - c0, 1);
      tick();
      chk("R7 next trigger gives 1", step, 1);
   endtask

   task automatic t_same_cycle();
      int c0;
      tick(); tick();
      chk("R2 step 3 before race", step, 3);
      c0 = adv_cnt;
      both_trig();
      chk("R8 race lands on 0", step, 0);
      chk("R8 race gives one strobe", adv_cnt - c0, 1);
      idle(LOCK + 5);
      tick();
      chk("R8 flag cleared, next is 1", step, 1);
   endtask

   task automatic t_sys_reset_mid();
      rst_trig();
      @(negedge clk) rst = 1'b1;
      idle(2);
      rst = 1'b0;
      idle(4);
      chk("R1 running after gate resync", running, 1);
      tick();
      chk("R1 pending and lockout cleared by reset", step, 1);
   endtask

   task automatic t_pulse_mode();
      int c0;
      set_run(1'b0);
      pmode = 1'b1;
      idle(2);
      chk("R5 starts stopped", running, 0);
      set_run(1'b1);
      set_run(1'b0);
      chk("R5 start pulse latches running", running, 1);
      c0 = adv_cnt;
      tick();
      chk("R5 running in pulse mode advances", adv_cnt - c0, 1);
      @(negedge clk) stop = 1'b1;
      idle(3);
      stop = 1'b0;
      idle(4);
      chk("R5 stop pulse clears running", running, 0);
      @(negedge clk) begin run = 1'b1; stop = 1'b1; end
      idle(3);
      run = 1'b0; stop = 1'b0;
      idle(4);
      chk("R5 stop wins over start when stopped", running, 0);
      set_run(1'b1);
      set_run(1'b0);
      @(negedge clk) begin run = 1'b1; stop = 1'b1; end
      idle(3);
      run = 1'b0; stop = 1'b0;
      idle(4);
      chk("R5 stop wins over start when running", running, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1;
      trig_clk = 1'b0;
      trig_rst = 1'b0;
      run = 1'b0;
      stop = 1'b0;
      pmode = 1'b0;
      len = 5'd8;
      idle(4);
      rst = 1'b0;
      idle(2);
      t_reset_state();
      t_latency();
      t_wrap();
      t_pause_and_pending();
      t_lockout();
      t_same_cycle();
      t_sys_reset_mid();
      t_pulse_mode();
      finish_run();
   end

endmodule